// File: doc/BRIEF.md
# Boot ROM Address Window Guard

This block sits in front of a boot ROM space and screens every host memory request against four programmable protection windows. Each window is one 32-bit control word. That word holds a 2 KB-aligned base, a length in kilobytes, and separate read-deny and write-deny bits. A request whose address falls inside a window that denies its direction is refused. The refused request is flagged in the same cycle, followed by a one-cycle error pulse. Every other request is granted. A refused read returns all ones to the host instead of ROM data.

Boot firmware programs the windows and sets their deny bits. From then on the deny bits cannot be cleared, and the window cannot be moved, until a full reset. The ROM therefore stays locked for the rest of the session. Covering a 1 MB ROM that ends at the top of the address space takes two adjacent 512 KB windows.

Top module: `rom_window_guard`

## Requirements
- R1: After reset all four control words read 0 and every request is granted, with the error output low.
- R2: The control words sit at byte offsets 0x50, 0x54, 0x58 and 0x5C of the configuration port, with word i at offset 0x50 + 4*i. Inside a word, bits 31:11 are the base address (its bits 10:0 are taken as 0), bits 10:2 are the length in KB minus one, bit 1 is read-deny and bit 0 is write-deny. While unlocked, a word reads back exactly as written. Any other offset reads 0, and a write to it changes nothing.
- R3: A window covers every address from base through base + (length field * 1024) + 1023, with both ends inclusive.
- R4: A write is refused when any window with write-deny covers its address. A read is refused when any window with read-deny covers its address. Windows may overlap, and a window with only read-deny does not refuse writes.
- R5: A deny bit, once set, stays set: writing 0 to it has no effect, and only reset clears it.
- R6: While either deny bit of a word is set, writes to that word's base and length fields are ignored. A write may still add the other deny bit.
- R7: In the cycle a request is presented, exactly one of grant and block is high. With no request, both are low.
- R8: The error output is high in the cycle after each refused request and low in the cycle after any other cycle. Back-to-back refusals keep it high.
- R9: A refused read returns all ones on the host data output. Any other cycle passes the ROM data through unchanged.
- R10: Two 512 KB write-deny windows at 0xFFF00000 and 0xFFF80000 refuse every write from 0xFFF00000 up to and including 0xFFFFFFFF. A write just below that range is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Control word at cfg_addr_i (combinational) |
| req_valid_i | input | 1 | Host request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Host request address |
| rom_rdata_i | input | DATA_W | Data returned by the ROM |
| req_grant_o | output | 1 | Request allowed |
| req_block_o | output | 1 | Request refused |
| host_rdata_o | output | DATA_W | Read data to host (all ones when refused) |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions check on every cycle that:
- deny bits never fall while reset is inactive;
- a locked word's base and length hold still;
- grant and block are mutually exclusive and follow the request strobe;
- the error pulse tracks the previous cycle's refusal;
- a refused read drives all ones.

Only the bench scenarios can show the window arithmetic:
- the inclusive ends of a window;
- the 512 KB windows that reach 0xFFFFFFFF;
- overlapping windows with different deny directions;
- unused configuration offsets;
- the reset that finally releases a lock.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BASE_LSB = 11;
  localparam int unsigned LEN_W    = 9;
  localparam int unsigned KB_SHIFT = 10;
  localparam int unsigned BASE_W   = REG_W - BASE_LSB;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LEN_W-1:0]  len_m1;
    logic              rd_deny;
    logic              wr_deny;
  } win_word_t;
endpackage

// File: rtl/rwg_cfg_decode.sv
module rwg_cfg_decode #(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h50
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  output logic [NUM_WIN-1:0]  sel_o
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_sel
    localparam logic [CFG_AW-1:0] OFS = CFG_AW'(REG_BASE + 4 * i);
    assign sel_o[i] = (cfg_addr_i == OFS);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R2
endmodule

// File: rtl/rwg_window.sv
module rwg_window
  import rwg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  win_word_t        wdata_i,
  input  logic [REG_W-1:0] req_addr_i,
  output win_word_t        word_o,
  output logic             rd_hit_o,
  output logic             wr_hit_o
);
  localparam int unsigned CMP_W = REG_W + 1;
  localparam int unsigned PAD_W = CMP_W - LEN_W - KB_SHIFT;

  win_word_t        word_q;
  logic             locked;
  logic [CMP_W-1:0] lo, hi, addr_x;
  logic             in_win;

  assign locked = word_q.rd_deny | word_q.wr_deny;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (wr_en_i) begin
      // deny bits only accumulate; geometry frozen once any is set
      word_q.rd_deny <= word_q.rd_deny | wdata_i.rd_deny;
      word_q.wr_deny <= word_q.wr_deny | wdata_i.wr_deny;
      if (!locked) begin
        word_q.base   <= wdata_i.base;
        word_q.len_m1 <= wdata_i.len_m1;
      end
    end
  end

  // 33-bit compare so a window past the top never wraps
  assign lo     = {1'b0, word_q.base, {BASE_LSB{1'b0}}};
  assign hi     = lo + {{PAD_W{1'b0}}, word_q.len_m1, {KB_SHIFT{1'b1}}};
  assign addr_x = {1'b0, req_addr_i};
  assign in_win = (addr_x >= lo) && (addr_x <= hi);

  assign rd_hit_o = in_win & word_q.rd_deny;
  assign wr_hit_o = in_win & word_q.wr_deny;
  assign word_o   = word_q;

  AST_DENY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q.rd_deny |=> word_q.rd_deny) and (word_q.wr_deny |=> word_q.wr_deny)); // R5
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ($stable(word_q.base) && $stable(word_q.len_m1))); // R6
endmodule

// File: rtl/rwg_resp.sv
module rwg_resp #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [NUM_WIN-1:0] rd_hits_i,
  input  logic [NUM_WIN-1:0] wr_hits_i,
  input  logic [DATA_W-1:0]  rom_rdata_i,
  output logic               grant_o,
  output logic               block_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  logic denied, err_q;

  assign denied  = req_write_i ? (|wr_hits_i) : (|rd_hits_i);
  assign block_o = req_valid_i & denied;
  assign grant_o = req_valid_i & ~denied;
  assign rdata_o = (block_o & ~req_write_i) ? '1 : rom_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= block_o;
  end
  assign err_o = err_q;

  AST_ERR_AFTER_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> err_o); // R8
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block_o |=> !err_o); // R8
endmodule

// File: rtl/rom_window_guard.sv
module rom_window_guard
  import rwg_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h50,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [REG_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              req_grant_o,
  output logic              req_block_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              err_o
);
  logic [NUM_WIN-1:0] sel, rd_hits, wr_hits;
  win_word_t          words [NUM_WIN];

  rwg_cfg_decode #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_addr_i (cfg_addr_i),
    .sel_o      (sel)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    rwg_window u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (cfg_we_i & sel[i]),
      .wdata_i    (win_word_t'(cfg_wdata_i)),
      .req_addr_i (req_addr_i),
      .word_o     (words[i]),
      .rd_hit_o   (rd_hits[i]),
      .wr_hit_o   (wr_hits[i])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel[i]) cfg_rdata_o = cfg_rdata_o | REG_W'(words[i]);
    end
  end

  rwg_resp #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .rd_hits_i   (rd_hits),
    .wr_hits_i   (wr_hits),
    .rom_rdata_i (rom_rdata_i),
    .grant_o     (req_grant_o),
    .block_o     (req_block_o),
    .rdata_o     (host_rdata_o),
    .err_o       (err_o)
  );

  AST_GRANT_BLOCK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_grant_o ^ req_block_o)); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!req_grant_o && !req_block_o)); // R7
  AST_WRITE_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && (|wr_hits)) |-> req_block_o); // R4
  AST_BLOCKED_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_block_o && !req_write_i) |-> (host_rdata_o == '1)); // R9
endmodule

// File: tb/rom_window_guard_tb_top.sv
module rom_window_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] rom_rdata = 32'h1234_5678;
  logic        grant, block, err;
  logic [31:0] host_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] ROM_WORD = 32'h1234_5678;

  always #5 clk = ~clk;

  rom_window_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .rom_rdata_i(rom_rdata), .req_grant_o(grant), .req_block_o(block),
    .host_rdata_o(host_rdata), .err_o(err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_chk(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    @(negedge clk); cfg_addr = ofs; #1;
    chk(req, $sformatf("word@%h", ofs), cfg_rdata, exp);
  endtask

  task automatic access(input string req, input logic [31:0] a, input bit wr, input bit exp_blk);
    @(negedge clk); req_valid = 1'b1; req_write = wr; req_addr = a; #1;
    chk(req, $sformatf("grant %h wr=%0d", a, wr), {31'b0, grant}, {31'b0, !exp_blk});
    chk(req, $sformatf("block %h wr=%0d", a, wr), {31'b0, block}, {31'b0, exp_blk});
    if (!wr) chk("R9", $sformatf("rdata %h", a), host_rdata, exp_blk ? 32'hFFFF_FFFF : ROM_WORD);
    @(negedge clk); req_valid = 1'b0; #1;
    chk("R8", $sformatf("err after %h", a), {31'b0, err}, {31'b0, exp_blk});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) cfg_chk("R1", 8'(8'h50 + 4 * i), 32'h0);
    access("R1", 32'hFFFF_FFFF, 1'b1, 1'b0);
    access("R1", 32'h0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_map;
    cfg_wr(8'h54, 32'h0001_0000 | (32'd3 << 2));
    cfg_chk("R2", 8'h54, 32'h0001_000C);
    cfg_wr(8'h60, 32'hFFFF_FFFF);
    cfg_chk("R2", 8'h60, 32'h0);
    cfg_chk("R2", 8'h50, 32'h0);
    cfg_chk("R2", 8'h5C, 32'h0);
  endtask

  task automatic t_bounds;
    cfg_wr(8'h54, 32'h0001_000D);
    access("R3", 32'h0000_FFFF, 1'b1, 1'b0);
    access("R3", 32'h0001_0000, 1'b1, 1'b1);
    access("R3", 32'h0001_0FFF, 1'b1, 1'b1);
    access("R3", 32'h0001_1000, 1'b1, 1'b0);
    access("R4", 32'h0001_0000, 1'b0, 1'b0);
  endtask

  task automatic t_sticky;
    cfg_wr(8'h54, 32'h0);
    cfg_chk("R5", 8'h54, 32'h0001_000D);
    access("R5", 32'h0001_0800, 1'b1, 1'b1);
    cfg_wr(8'h54, 32'h0002_0000 | 32'h3);
    cfg_chk("R6", 8'h54, 32'h0001_000F);
    access("R6", 32'h0002_0000, 1'b1, 1'b0);
    access("R9", 32'h0001_0800, 1'b0, 1'b1);
  endtask

  task automatic t_rom;
    cfg_wr(8'h50, 32'hFFF0_07FD);
    cfg_wr(8'h58, 32'hFFF8_07FD);
    access("R10", 32'hFFEF_FFFF, 1'b1, 1'b0);
    access("R10", 32'hFFF0_0000, 1'b1, 1'b1);
    access("R10", 32'hFFF7_FFFF, 1'b1, 1'b1);
    access("R10", 32'hFFF8_0000, 1'b1, 1'b1);
    access("R10", 32'hFFFF_FFFF, 1'b1, 1'b1);
    access("R10", 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_overlap;
    cfg_wr(8'h5C, 32'hFFFC_0002);
    access("R4", 32'hFFFC_0000, 1'b0, 1'b1);
    access("R4", 32'hFFFC_03FF, 1'b0, 1'b1);
    access("R4", 32'hFFFC_0400, 1'b0, 1'b0);
    access("R4", 32'hFFFC_0000, 1'b1, 1'b1);
  endtask

  task automatic t_b2b;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hFFF0_1000;
    @(negedge clk); req_addr = 32'hFFF9_0000; #1;
    chk("R8", "err b2b first", {31'b0, err}, 32'h1);
    @(negedge clk); req_valid = 1'b0; #1;
    chk("R8", "err b2b second", {31'b0, err}, 32'h1);
    @(negedge clk); #1;
    chk("R8", "err b2b end", {31'b0, err}, 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk); req_valid = 1'b0; req_write = 1'b1; req_addr = 32'hFFFF_0000; #1;
    chk("R7", "idle grant", {31'b0, grant}, 32'h0);
    chk("R7", "idle block", {31'b0, block}, 32'h0);
    @(negedge clk); #1;
    chk("R8", "idle err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_chk("R5", 8'h54, 32'h0);
    cfg_chk("R1", 8'h50, 32'h0);
    access("R1", 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_bounds();
    t_sticky();
    t_rom();
    t_overlap();
    t_b2b();
    t_idle();
    t_rereset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule